// File: doc/BRIEF.md
# Sequential Loop Instruction Buffer

This block is a small instruction store that sits next to the level-one instruction cache and holds a single tight loop. It watches each fetched instruction for a taken branch that jumps back by a short distance. When it sees one, it records that branch as the closing branch of a loop. On the next pass through the loop it copies every instruction into its own storage, in address order. It needs no tags: the loop is identified by the address of its closing branch and the start address that branch targets.

Once a full pass has been captured without a break, the block serves every later pass from its own storage. It raises a select output that steers the fetch multiplexer away from the level-one cache. Because the loop body is known to be complete, there is never a miss. A fill can only be sequential. If any other taken change of flow occurs during capture, or if the fetch address skips ahead, the capture is abandoned and the block goes back to idle. If a different short backward branch is taken while filling, capture restarts on that new loop. The block returns to idle when the program leaves the loop, either because the closing branch falls through or because the fetch address leaves the captured range.

Top module: `seq_loop_cache`

## Requirements
- R1: After a synchronous reset the state output reads idle (0), the select output is 0 and the output instruction equals the incoming level-one word.
- R2: In idle, a fetch marked as a taken change of flow with a negative offset whose magnitude is at most DEPTH-1 (so the loop, including its branch, fits in DEPTH entries) moves the state to fill (1) on the next cycle.
- R3: A backward offset of magnitude DEPTH or more, a non-negative offset, or a change of flow that is not taken leaves an idle block in idle.
- R4: In fill, instructions are written at consecutive entries starting at the branch target. When the closing branch is reached in order and taken, the state becomes active (2) on the next cycle.
- R5: In active, any fetch address from the branch target up to the closing branch address raises select in the same cycle, and the output instruction is the captured word, whatever the level-one word is.
- R6: A taken change of flow during fill, other than a short backward branch, returns the state to idle, and the loop is not served afterwards.
- R7: During fill, a fetch address that is not the next sequential address returns the state to idle.
- R8: In active, when the closing branch is fetched and not taken, it is still served from the buffer, the state then becomes idle, and the next fetch has select low.
- R9: In active, a fetch address outside the captured range has select low in that cycle. The state becomes idle next, or becomes fill if that fetch is itself a taken short backward branch.
- R10: In fill, a taken short backward branch at an address other than the recorded closing branch restarts capture for the new loop. That loop then becomes active after one sequential pass.
- R11: Select is never high while the state is idle or fill, and in those states the output instruction is the level-one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 16 | Word address of the current fetch |
| instr_i | input | IW | Instruction word from the level-one cache |
| br_taken_i | input | 1 | Current instruction is a branch that is taken |
| cof_i | input | 1 | Current instruction is a change of flow |
| br_off_i | input | OFF_W | Signed word offset of the branch |
| instr_o | output | IW | Instruction word delivered to the processor |
| use_buf_o | output | 1 | High when the word comes from the loop buffer |
| state_o | output | 2 | Controller state: 0 idle, 1 fill, 2 active |

## Verification
The hardest case to reach is a loop that fills the buffer to its last entry and is then served in full. This needs a backward offset of exactly DEPTH-1, one plain pass, one capture pass and one serving pass. During the serving pass the level-one word is held at a fixed wrong value, so that only correct buffer contents can match. The capture-restart path is also hard to reach. It is driven with a one-instruction inner loop whose backward branch is taken inside the capture of an enclosing loop, and then both passes of the inner loop are completed.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
    localparam int unsigned LC_PC_W = 16;

    typedef logic [LC_PC_W-1:0] pc_t;

    typedef enum logic [1:0] {
        LC_IDLE   = 2'd0,
        LC_FILL   = 2'd1,
        LC_ACTIVE = 2'd2
    } lc_state_e;

    // Address range of the loop held in the buffer
    typedef struct packed {
        pc_t head;   // branch target, entry 0
        pc_t tail;   // closing branch address
    } loop_span_t;

    function automatic logic in_span(loop_span_t s, pc_t pc);
        return (pc >= s.head) && (pc <= s.tail);
    endfunction
endpackage

// File: rtl/lc_sbb_detect.sv
`timescale 1ns/1ps
module lc_sbb_detect
    import lc_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned OFF_W = 8
) (
    input  pc_t              pc_i,
    input  logic             br_taken_i,
    input  logic             cof_i,
    input  logic [OFF_W-1:0] br_off_i,
    output logic             hit_o,
    output pc_t              target_o
);
    localparam int unsigned LIMIT = DEPTH - 1;

    logic [OFF_W-1:0] mag;
    pc_t              off_ext;

    assign mag      = (~br_off_i) + 1'b1;
    assign off_ext  = {{(LC_PC_W-OFF_W){br_off_i[OFF_W-1]}}, br_off_i};
    assign target_o = pc_i + off_ext;
    assign hit_o    = cof_i && br_taken_i && br_off_i[OFF_W-1]
                      && (32'(mag) <= LIMIT);
endmodule

// File: rtl/lc_store.sv
`timescale 1ns/1ps
module lc_store #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IW    = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [IW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [IW-1:0] rdata_o
);
    logic [IW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/lc_ctrl.sv
`timescale 1ns/1ps
module lc_ctrl
    import lc_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IW    = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  pc_t           pc_i,
    input  logic [IW-1:0] instr_i,
    input  logic          br_taken_i,
    input  logic          cof_i,
    input  logic          sbb_hit_i,
    input  pc_t           sbb_target_i,
    output lc_state_e     state_o,
    output logic          serve_o,
    output logic [AW-1:0] rd_idx_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_idx_o,
    output logic [IW-1:0] wr_data_o
);
    lc_state_e  state_q, state_d;
    loop_span_t span_q, span_d;
    logic [CW-1:0] cnt_q, cnt_d;

    logic in_rng, seq_ok, at_tail, taken_cof;
    pc_t  expect_pc;

    assign in_rng    = in_span(span_q, pc_i);
    assign expect_pc = span_q.head + pc_t'(cnt_q);
    assign seq_ok    = (pc_i == expect_pc);
    assign at_tail   = (pc_i == span_q.tail);
    assign taken_cof = cof_i && br_taken_i;

    always_comb begin
        state_d = state_q;
        span_d  = span_q;
        cnt_d   = cnt_q;
        wr_en_o = 1'b0;
        case (state_q)
            LC_IDLE: begin
                if (sbb_hit_i) begin
                    state_d = LC_FILL;
                    span_d  = '{head: sbb_target_i, tail: pc_i};
                    cnt_d   = '0;
                end
            end
            LC_FILL: begin
                if (at_tail && seq_ok && taken_cof) begin
                    wr_en_o = 1'b1;
                    state_d = LC_ACTIVE;
                end else if (sbb_hit_i) begin
                    span_d  = '{head: sbb_target_i, tail: pc_i};
                    cnt_d   = '0;
                end else if (!seq_ok || taken_cof || at_tail) begin
                    state_d = LC_IDLE;
                end else begin
                    wr_en_o = 1'b1;
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            LC_ACTIVE: begin
                if (!in_rng) begin
                    if (sbb_hit_i) begin
                        state_d = LC_FILL;
                        span_d  = '{head: sbb_target_i, tail: pc_i};
                        cnt_d   = '0;
                    end else begin
                        state_d = LC_IDLE;
                    end
                end else if (at_tail && !br_taken_i) begin
                    state_d = LC_IDLE;
                end
            end
            default: state_d = LC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LC_IDLE;
            span_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            span_q  <= span_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o   = state_q;
    assign serve_o   = (state_q == LC_ACTIVE) && in_rng;
    assign rd_idx_o  = AW'(pc_i - span_q.head);
    assign wr_idx_o  = cnt_q[AW-1:0];
    assign wr_data_o = instr_i;

    // R4: active is entered only from fill on a taken closing branch
    assert_enter_active_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == LC_ACTIVE && $past(state_q) == LC_FILL) |-> $past(taken_cof));

    // R6: taken non-loop change of flow during fill aborts capture
    assert_abort_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == LC_FILL && taken_cof && !sbb_hit_i) |=> state_q == LC_IDLE);

    // R8: closing branch falling through ends serving
    assert_exit_fallthru_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == LC_ACTIVE && in_rng && at_tail && !br_taken_i) |=> state_q == LC_IDLE);

    // R9: fetch outside the range leaves active
    assert_exit_range_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == LC_ACTIVE && !in_rng && !sbb_hit_i) |=> state_q == LC_IDLE);

    // R4: capture never writes past the last entry
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (32'(cnt_q) < DEPTH));
endmodule

// File: rtl/seq_loop_cache.sv
`timescale 1ns/1ps
module seq_loop_cache
    import lc_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IW    = 32,
    parameter int unsigned OFF_W = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LC_PC_W-1:0]   pc_i,
    input  logic [IW-1:0]        instr_i,
    input  logic                 br_taken_i,
    input  logic                 cof_i,
    input  logic [OFF_W-1:0]     br_off_i,
    output logic [IW-1:0]        instr_o,
    output logic                 use_buf_o,
    output logic [1:0]           state_o
);
    logic          sbb_hit;
    pc_t           sbb_target;
    lc_state_e     st;
    logic          serve;
    logic [AW-1:0] rd_idx, wr_idx;
    logic          wr_en;
    logic [IW-1:0] wr_data, rd_data;

    lc_sbb_detect #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_det (
        .pc_i(pc_i), .br_taken_i(br_taken_i), .cof_i(cof_i),
        .br_off_i(br_off_i), .hit_o(sbb_hit), .target_o(sbb_target)
    );

    lc_ctrl #(.DEPTH(DEPTH), .IW(IW)) u_ctrl (
        .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i),
        .br_taken_i(br_taken_i), .cof_i(cof_i),
        .sbb_hit_i(sbb_hit), .sbb_target_i(sbb_target),
        .state_o(st), .serve_o(serve), .rd_idx_o(rd_idx),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
    );

    lc_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
        .clk(clk), .we_i(wr_en), .waddr_i(wr_idx), .wdata_i(wr_data),
        .raddr_i(rd_idx), .rdata_o(rd_data)
    );

    assign use_buf_o = serve;
    assign instr_o   = serve ? rd_data : instr_i;
    assign state_o   = st;

    // R3: long backward branch seen in idle does not start a fill
    assert_long_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (st == LC_IDLE && cof_i && br_taken_i
         && int'($signed(br_off_i)) <= -int'(DEPTH)) |=> state_o == 2'd0);

    // R11: buffer selected only while serving
    assert_sel_active_R11: assert property (@(posedge clk) disable iff (rst)
        use_buf_o |-> state_o == 2'd2);
endmodule

// File: tb/seq_loop_cache_test.sv
`timescale 1ns/1ps
module seq_loop_cache_test;
    localparam int DEPTH = 32;
    localparam int IW    = 32;
    localparam int OFF_W = 8;
    localparam logic [IW-1:0] BAD = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0]      pc_i = '0;
    logic [IW-1:0]    instr_i = '0;
    logic             br_taken_i = 1'b0;
    logic             cof_i = 1'b0;
    logic [OFF_W-1:0] br_off_i = '0;
    logic [IW-1:0]    instr_o;
    logic             use_buf_o;
    logic [1:0]       state_o;

    int total = 0;
    int fails = 0;
    logic done = 1'b0;

    logic          o_sel;
    logic [IW-1:0] o_instr;
    logic [1:0]    o_state;

    always #2 clk = ~clk;

    seq_loop_cache #(.DEPTH(DEPTH), .IW(IW), .OFF_W(OFF_W)) uut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i),
        .br_taken_i(br_taken_i), .cof_i(cof_i), .br_off_i(br_off_i),
        .instr_o(instr_o), .use_buf_o(use_buf_o), .state_o(state_o)
    );

    function automatic logic [IW-1:0] l1w(input logic [15:0] pc);
        return {16'hC0DE, pc};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int pc, input logic tk, input logic cf,
                        input int off, input logic good);
        @(negedge clk);
        pc_i       = 16'(pc);
        br_taken_i = tk;
        cof_i      = cf;
        br_off_i   = OFF_W'(off);
        instr_i    = good ? l1w(16'(pc)) : BAD;
        #1;
        o_sel   = use_buf_o;
        o_instr = instr_o;
        o_state = state_o;
    endtask

    task automatic state_after(input string tag, input logic [1:0] exp);
        @(posedge clk);
        #1;
        chk(tag, 32'(state_o), 32'(exp));
    endtask

    task automatic t_reset();
        step(50, 0, 0, 0, 1);
        chk("R1 state", 32'(o_state), 0);
        chk("R1 sel", 32'(o_sel), 0);
        chk("R1 instr", o_instr, l1w(50));
    endtask

    task automatic t_basic();
        for (int i = 0; i < 4; i++) step(100 + i, 0, 0, 0, 1);
        step(104, 1, 1, -4, 1);
        state_after("R2 enter fill", 2'd1);
        for (int i = 0; i < 4; i++) begin
            step(100 + i, 0, 0, 0, 1);
            chk("R11 sel in fill", 32'(o_sel), 0);
            chk("R11 instr in fill", o_instr, l1w(16'(100 + i)));
        end
        step(104, 1, 1, -4, 1);
        state_after("R4 enter active", 2'd2);
        for (int i = 0; i < 5; i++) begin
            step(100 + i, i == 4, i == 4, (i == 4) ? -4 : 0, 0);
            chk("R5 sel", 32'(o_sel), 1);
            chk("R5 instr", o_instr, l1w(16'(100 + i)));
        end
        for (int i = 0; i < 4; i++) step(100 + i, 0, 0, 0, 0);
        step(104, 0, 1, -4, 0);
        chk("R8 tail served", o_instr, l1w(104));
        chk("R8 tail sel", 32'(o_sel), 1);
        state_after("R8 idle after exit", 2'd0);
        step(105, 0, 0, 0, 1);
        chk("R8 sel after exit", 32'(o_sel), 0);
    endtask

    task automatic t_ignored();
        step(150, 1, 1, -32, 1);
        state_after("R3 offset -DEPTH", 2'd0);
        step(151, 1, 1, -100, 1);
        state_after("R3 far backward", 2'd0);
        step(152, 0, 1, -4, 1);
        state_after("R3 not taken", 2'd0);
        step(153, 1, 1, 3, 1);
        state_after("R3 forward", 2'd0);
        step(160, 1, 1, -31, 1);
        state_after("R2 offset -(DEPTH-1)", 2'd1);
        step(500, 0, 0, 0, 1);
        state_after("R7 skip breaks fill", 2'd0);
    endtask

    task automatic t_abort();
        step(205, 1, 1, -5, 1);
        state_after("R2 fill for abort", 2'd1);
        step(200, 0, 0, 0, 1);
        step(201, 0, 0, 0, 1);
        step(202, 1, 1, 2, 1);
        state_after("R6 abort", 2'd0);
        step(204, 0, 0, 0, 1);
        chk("R6 no serve", 32'(o_sel), 0);
        step(205, 1, 1, -5, 1);
        state_after("R6 refill", 2'd1);
        step(200, 0, 0, 0, 1);
        step(201, 0, 0, 0, 1);
        step(202, 1, 1, 2, 1);
        step(204, 0, 0, 0, 0);
        chk("R6 still no serve", 32'(o_sel), 0);
        chk("R6 l1 word", o_instr, BAD);
    endtask

    task automatic t_restart();
        step(304, 1, 1, -4, 1);
        state_after("R10 outer fill", 2'd1);
        step(300, 0, 0, 0, 1);
        step(301, 1, 1, -1, 1);
        state_after("R10 restart", 2'd1);
        step(300, 0, 0, 0, 1);
        step(301, 1, 1, -1, 1);
        state_after("R10 inner active", 2'd2);
        step(300, 0, 0, 0, 0);
        chk("R10 serve sel", 32'(o_sel), 1);
        chk("R10 serve instr", o_instr, l1w(300));
        step(310, 0, 0, 0, 1);
        chk("R9 out of range sel", 32'(o_sel), 0);
        chk("R9 out of range instr", o_instr, l1w(310));
        state_after("R9 idle", 2'd0);
    endtask

    task automatic t_full();
        step(431, 1, 1, -31, 1);
        state_after("R2 full fill", 2'd1);
        for (int i = 0; i < 31; i++) step(400 + i, 0, 0, 0, 1);
        step(431, 1, 1, -31, 1);
        state_after("R4 full active", 2'd2);
        for (int i = 0; i < 32; i++) begin
            step(400 + i, i == 31, i == 31, (i == 31) ? -31 : 0, 0);
            chk("R5 full entry", o_instr, l1w(16'(400 + i)));
        end
        chk("R5 last sel", 32'(o_sel), 1);
        step(500, 1, 1, -2, 1);
        chk("R9 new loop sel", 32'(o_sel), 0);
        state_after("R9 new loop fill", 2'd1);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_ignored();
        t_abort();
        t_restart();
        t_full();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule